// File: doc/BRIEF.md
# Atomic Masked Read-Modify-Write Unit

This unit updates selected bits of one 32-bit word in memory as a single indivisible step. A requester supplies a 64-bit operand and a word address. The lower half of the operand is the new data. The upper half is a bit mask. The unit reads the word, replaces only the bits whose mask bit is set, and writes the result back to the same address. A lock output stays high for the whole read-to-write span, so that a shared-memory arbiter can refuse every other requester until the update has landed.

A request is taken with a start/ready handshake. Completion is reported by a one-cycle done pulse, and an error flag is valid alongside it. An address that is not word-aligned is rejected at once: no memory access is made, and done rises together with the error flag. The memory side is a simple synchronous port. A request is accepted on any clock edge where grant is high, and read data is returned in the cycle after a read is accepted.

Top module: `masked_rmw_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, ready_o is 1 and lock_o, mem_req_o, done_o and err_o are 0.
- R2: A request is taken only on an edge where start_i and ready_o are both 1. The operand and the address are captured on that edge. Later changes to operand_i, addr_i or start_i have no effect until ready_o is high again.
- R3: The word written back equals (old AND NOT mask) OR (value AND mask), where the value is operand bits 31:0 and the mask is operand bits 63:32.
- R4: With a mask of all zeros, the read and the write still take place, and the word written back equals the word read.
- R5: With a mask of all ones, the word written back equals the value field.
- R6: Each aligned request makes exactly one read (mem_we_o=0), followed by exactly one write (mem_we_o=1) to the same address.
- R7: lock_o is high from the first cycle of the read request through the cycle in which the write is accepted, and only then. With a grant delay of w cycles on each access, that span is 2w+3 cycles. mem_req_o is never high while lock_o is low.
- R8: While mem_req_o is high and mem_gnt_i is low, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold their values.
- R9: If addr_i bits 1:0 are not 00 when a request is taken, no memory request is made, and done_o and err_o are both 1 in the next cycle.
- R10: done_o is high for exactly one cycle, after which ready_o is 1. err_o is 0 on a completed aligned request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| ready_o | output | 1 | Idle and able to take a request |
| operand_i | input | 64 | Mask in bits 63:32, value in bits 31:0 |
| addr_i | input | 32 | Byte address of the target word |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned request; valid with done_o |
| lock_o | output | 1 | Holds the memory for the read-to-write span |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Merged write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read is accepted |
| mem_gnt_i | input | 1 | Memory accepts the current request |

## Verification
The bench attacks the all-zero and all-one masks and an alternating mask. A design that skipped the read for a null mask would leave the write count short, and a design that inverted the merge select would scramble the word. Grant wait states are inserted on both accesses. A unit that dropped lock between the read and the write, or moved on without a grant, would show the wrong lock span or a corrupted word. A misaligned address must finish in one cycle with no access. The operand, the address and the start strobe are also changed mid-operation: a unit that re-sampled its inputs, or took a second start, would write the wrong word or an extra word.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MERGE,
    ST_WRITE,
    ST_DONE
  } rmw_state_t;
endpackage

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [OFF_W-1:0] addr_lo_i,
  input  logic             mem_gnt_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             lock_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             done_o,
  output logic             err_o
);
  rmw_state_t state_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (addr_lo_i != '0) begin
            state_q <= ST_DONE;
            err_q   <= 1'b1;
          end else begin
            state_q <= ST_READ;
            err_q   <= 1'b0;
          end
        end
        ST_READ:  if (mem_gnt_i) state_q <= ST_MERGE;
        ST_MERGE: state_q <= ST_WRITE;
        ST_WRITE: if (mem_gnt_i) state_q <= ST_DONE;
        ST_DONE: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && start_i;
  assign capture_o = (state_q == ST_MERGE);
  assign lock_o    = (state_q == ST_READ) || (state_q == ST_MERGE) || (state_q == ST_WRITE);
  assign mem_req_o = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o  = (state_q == ST_WRITE);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = err_q;

  // R1: idle and clean immediately after reset
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (ready_o && !lock_o && !done_o && !err_o));

  // R7: any memory request is covered by the lock
  assert_req_locked_R7: assert property (@(posedge clk) disable iff (rst) mem_req_o |-> lock_o);

  // R6: an accepted read is followed by a gap cycle and then the write
  assert_read_then_write_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o && mem_gnt_i) |=> (!mem_req_o && lock_o));

  // R9: misaligned request finishes next cycle with the error flag
  assert_misalign_err_R9: assert property (@(posedge clk) disable iff (rst)
    (accept_o && addr_lo_i != '0) |=> (done_o && err_o && !mem_req_o));

  // R10: done is a single-cycle pulse that returns to ready
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && ready_o));
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept_i,
  input  logic                capture_i,
  input  logic [2*DATA_W-1:0] operand_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o
);
  logic [DATA_W-1:0] value_q, mask_q, merged_q, merged_d;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
    end else if (accept_i) begin
      value_q <= operand_i[DATA_W-1:0];
      mask_q  <= operand_i[2*DATA_W-1:DATA_W];
      addr_q  <= addr_i;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign merged_d[b] = mask_q[b] ? value_q[b] : rdata_i[b];
  end

  always_ff @(posedge clk) begin
    if (rst) merged_q <= '0;
    else if (capture_i) merged_q <= merged_d;
  end

  assign addr_o  = addr_q;
  assign wdata_o = merged_q;

  // R3: unmasked bits follow the word read from memory
  assert_keep_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (((merged_q ^ $past(rdata_i)) & ~mask_q) == '0));

  // R3: masked bits follow the value field
  assert_take_masked_R3: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (((merged_q ^ value_q) & mask_q) == '0));
endmodule

// File: rtl/masked_rmw_unit.sv
module masked_rmw_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  output logic                ready_o,
  input  logic [2*DATA_W-1:0] operand_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                done_o,
  output logic                err_o,
  output logic                lock_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_gnt_i
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic accept, capture;

  rmw_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .addr_lo_i (addr_i[OFF_W-1:0]),
    .mem_gnt_i (mem_gnt_i),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .capture_o (capture),
    .lock_o    (lock_o),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  rmw_merge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .capture_i (capture),
    .operand_i (operand_i),
    .addr_i    (addr_i),
    .rdata_i   (mem_rdata_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o)
  );

  // R8: a stalled request holds all of its fields
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                    $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R2: address stays fixed while the unit is busy
  assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && !done_o) |=> $stable(mem_addr_o));
endmodule

// File: tb/sim_masked_rmw_unit.sv
module sim_masked_rmw_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        ready, done, err, lock, mem_req, mem_we, gnt;
  logic [63:0] operand;
  logic [31:0] addr, mem_addr, mem_wdata, rdata;

  logic [31:0] mem [16];
  int rd_cnt = 0, wr_cnt = 0, wait_cfg = 0, wait_ctr = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  masked_rmw_unit u0 (
    .clk(clk), .rst(rst), .start_i(start), .ready_o(ready),
    .operand_i(operand), .addr_i(addr), .done_o(done), .err_o(err),
    .lock_o(lock), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata), .mem_gnt_i(gnt)
  );

  assign gnt = (wait_ctr == 0);

  always @(posedge clk) begin
    if (mem_req) begin
      if (wait_ctr != 0) wait_ctr <= wait_ctr - 1;
      else begin
        wait_ctr <= wait_cfg;
        if (mem_we) begin
          mem[mem_addr[5:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
        end else begin
          rdata <= mem[mem_addr[5:2]];
          rd_cnt <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] op, input logic [31:0] a, input int w,
                        input bit poke, output int cyc, output int lockc, output logic e);
    @(negedge clk);
    wait_cfg = w; wait_ctr = w;
    operand = op; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0; operand = '1; addr = 32'h4;
    cyc = 1; lockc = 0;
    while (!done && cyc < 100) begin
      if (lock) lockc++;
      if (poke && cyc == 2) begin start = 1'b1; addr = 32'h20; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    e = err;
    start = 1'b0;
    @(negedge clk);
    chk("R10 done pulse width", {31'd0, done}, 32'd0);
    chk("R10 ready after done", {31'd0, ready}, 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; operand = '0; addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, ready}, 32'd1);
    chk("R1 lock/req/done/err low", {28'd0, lock, mem_req, done, err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, ready, lock, mem_req}, 32'd4);
  endtask

  task automatic t_basic();
    int c, l; logic e; int r0, w0;
    mem[3] = 32'hA5A5_0F0F; mem[1] = 32'h1111_1111; mem[8] = 32'h8888_8888;
    r0 = rd_cnt; w0 = wr_cnt;
    run_op({32'hFFFF_0000, 32'h1234_5678}, 32'h0000_000C, 0, 1'b1, c, l, e);
    chk("R3 merged word", mem[3], 32'h1234_0F0F);
    chk("R6 one read", rd_cnt - r0, 1);
    chk("R6 one write", wr_cnt - w0, 1);
    chk("R6 same address", last_wr_addr, last_rd_addr);
    chk("R7 lock span w=0", l, 3);
    chk("R10 err low aligned", {31'd0, e}, 32'd0);
    chk("R2 late addr untouched", mem[1], 32'h1111_1111);
    chk("R2 busy start ignored", mem[8], 32'h8888_8888);
  endtask

  task automatic t_zero_mask();
    int c, l; logic e; int r0, w0;
    mem[5] = 32'hDEAD_BEEF;
    r0 = rd_cnt; w0 = wr_cnt;
    run_op({32'h0000_0000, 32'hFFFF_FFFF}, 32'h0000_0014, 0, 1'b0, c, l, e);
    chk("R4 word unchanged", mem[5], 32'hDEAD_BEEF);
    chk("R4 read still made", rd_cnt - r0, 1);
    chk("R4 write still made", wr_cnt - w0, 1);
  endtask

  task automatic t_full_mask();
    int c, l; logic e;
    mem[6] = 32'h0F0F_F0F0;
    run_op({32'hFFFF_FFFF, 32'hCAFE_F00D}, 32'h0000_0018, 0, 1'b0, c, l, e);
    chk("R5 value written", mem[6], 32'hCAFE_F00D);
  endtask

  task automatic t_stall();
    int c, l; logic e; int w0;
    mem[7] = 32'hFFFF_0000; mem[8] = 32'h8888_8888;
    w0 = wr_cnt;
    run_op({32'h5555_5555, 32'h0000_FFFF}, 32'h0000_001C, 2, 1'b1, c, l, e);
    chk("R8 merge under wait states", mem[7], 32'hAAAA_5555);
    chk("R7 lock span w=2", l, 7);
    chk("R8 completion latency", c, 8);
    chk("R2 single write under poke", wr_cnt - w0, 1);
    chk("R2 poke target untouched", mem[8], 32'h8888_8888);
  endtask

  task automatic t_misalign();
    int c, l; logic e; int r0, w0;
    mem[2] = 32'h2222_2222;
    r0 = rd_cnt; w0 = wr_cnt;
    run_op({32'hFFFF_FFFF, 32'h0}, 32'h0000_0009, 0, 1'b0, c, l, e);
    chk("R9 err with done", {31'd0, e}, 32'd1);
    chk("R9 done next cycle", c, 1);
    chk("R9 no access", (rd_cnt - r0) + (wr_cnt - w0), 0);
    chk("R9 no lock", l, 0);
    chk("R9 memory intact", mem[2], 32'h2222_2222);
  endtask

  task automatic t_back_to_back();
    int c, l; logic e;
    run_op({32'h0000_00FF, 32'h0000_00AB}, 32'h0000_000C, 1, 1'b0, c, l, e);
    chk("R3 second update same word", mem[3], 32'h1234_0FAB);
    chk("R7 lock span w=1", l, 5);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    rdata = '0;
    t_reset();
    t_basic();
    t_zero_mask();
    t_full_mask();
    t_stall();
    t_misalign();
    t_back_to_back();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule